// File: doc/BRIEF.md
# Write Completion Status Reporter

This block sits in the read path of a byte-programmable non-volatile memory. While a self-timed program cycle is running, it replaces normal read data with status, so that a host can tell when the cycle has finished without reading any dedicated register. It offers three end-of-write indicators at the same time. The first is a polled bit that reads as the inverse of the last written byte's top bit. The second is a bit that changes value on every read cycle. The third is a ready/busy pull-low enable for an open-drain line that several devices can share.

The program engine supplies a busy flag and the address and data of the last byte written, and holds them stable while busy. The array supplies read data for the presented address in the same clock cycle. The block samples the strobes on each rising clock edge and registers its outputs, so every output reflects the inputs sampled at the previous edge. Once the busy flag is low, reads pass the array data straight through.

Top module: `wcs_status_top`

## Requirements
- R1: After a synchronous reset with rst_n low, rd_drive_o, rb_pull_o and rd_data_o are all 0.
- R2: rd_drive_o is 1 in the cycle after an edge that sampled ce_n_i=0, oe_n_i=0 and we_n_i=1, and is 0 after any other sampled combination, which is the high-impedance state.
- R3: When rd_drive_o is 0, rd_data_o is 0. When rd_drive_o is 1 and busy_i was 0 at the sampling edge, rd_data_o equals the array_data_i sampled at that edge.
- R4: During a busy read of the address equal to last_addr_i, bit 7 of rd_data_o is the inverse of bit 7 of last_data_i.
- R5: During a busy read of any other address, bit 7 of rd_data_o is 0.
- R6: During a busy read, bits 5 down to 0 of rd_data_o are 0.
- R7: The toggle bit, bit 6 of rd_data_o, is cleared to 0 at the edge where busy_i is first seen high. At every edge that sees a new read cycle start while busy_i is high, it inverts, so the first busy read returns 1 and the following reads alternate.
- R8: The toggle bit keeps its value for every cycle of a read that lasts several clocks, and across idle cycles between reads.
- R9: rb_pull_o equals busy_i sampled at the previous edge, so the line is pulled low for the whole program cycle and released once it ends.
- R10: A read that is still in progress when busy_i falls switches to true array data in the cycle after the first edge that sees busy_i low, without needing a new read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| busy_i | input | 1 | Program cycle in progress |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Read address |
| array_data_i | input | DATA_W | Array read data for addr_i |
| last_addr_i | input | ADDR_W | Address of last byte written |
| last_data_i | input | DATA_W | Data of last byte written |
| rd_data_o | output | DATA_W | Value presented on the data bus |
| rd_drive_o | output | 1 | Bus drive enable; 0 means high impedance |
| rb_pull_o | output | 1 | Pull-low enable for the open-drain ready/busy line |

## Verification
Two of the block's functions can land on the same sampling edge. The first is the clearing of the toggle bit when busy rises. The second is its inversion by a read start. The bench provokes this collision by opening a read strobe on the very edge where busy first goes high. Here the clear comes first and the flip follows, so the read must show 1. The bench also does the reverse: it raises busy in the middle of a read that is already open, where no flip occurs and the read must show 0. In both cases the bench judges the result against its own cycle model, which is built from the requirements. Randomly timed busy windows and strobe patterns then cover the other overlaps between the two functions.

// File: rtl/wcs_pkg.sv
// Shared types for the write completion status reporter.
// Assumes: nothing beyond the 1800-2017 language.
package wcs_pkg;

    // Strobe decode result for one sampled clock edge
    typedef struct packed {
        logic active;   // read strobe combination present
        logic start;    // first cycle of a new read cycle
    } rd_strobe_t;

endpackage

// File: rtl/wcs_strobe_decode.sv
// Decodes the read strobe combination and finds the start of each read cycle.
// Assumes: strobes are synchronous to clk; a read start is the first sampled
// cycle with the combination present after a cycle without it.
module wcs_strobe_decode
    import wcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n_i,
    input  logic       oe_n_i,
    input  logic       we_n_i,
    output rd_strobe_t strobe_o
);

    logic rd_now;
    logic rd_prev_q;

    // Combination that places data on the bus
    always_comb begin
        rd_now          = !ce_n_i && !oe_n_i && we_n_i;
        strobe_o.active = rd_now;
        strobe_o.start  = rd_now && !rd_prev_q;
    end

    // Remember the previous cycle's read state for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) rd_prev_q <= 1'b0;
        else        rd_prev_q <= rd_now;
    end

endmodule

// File: rtl/wcs_toggle_track.sv
// Holds the per-read toggle flag used while a program cycle runs.
// Assumes: busy_i is high for the whole program cycle. The flag clears when
// busy is first seen, then flips once per read start while busy; the clear
// is applied before the flip on the same edge.
module wcs_toggle_track (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    input  logic rd_start_i,
    output logic tog_next_o
);

    logic busy_q;
    logic tog_q;
    logic tog_base;

    // Next toggle value: clear on busy rise, then flip on a busy read start
    always_comb begin
        tog_base   = (busy_i && !busy_q) ? 1'b0 : tog_q;
        tog_next_o = (busy_i && rd_start_i) ? !tog_base : tog_base;
    end

    // Toggle and busy history registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            tog_q  <= 1'b0;
        end else begin
            busy_q <= busy_i;
            tog_q  <= tog_next_o;
        end
    end

endmodule

// File: rtl/wcs_status_mux.sv
// Chooses between array data and the status word for the next bus value.
// Assumes: DATA_W >= 3; the poll bit is the top bit and the toggle bit is the
// one below it. Status bits below the toggle bit are driven as zero.
module wcs_status_mux #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              busy_i,
    input  logic              rd_active_i,
    input  logic              tog_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] array_data_i,
    input  logic [ADDR_W-1:0] last_addr_i,
    input  logic [DATA_W-1:0] last_data_i,
    output logic [DATA_W-1:0] data_next_o
);

    localparam int POLL_BIT = DATA_W - 1;
    localparam int TOG_BIT  = DATA_W - 2;

    logic [DATA_W-1:0] status_word;

    // Build the status word: inverted poll bit on a match, toggle bit below it
    always_comb begin
        status_word           = '0;
        status_word[POLL_BIT] = (addr_i == last_addr_i) ? !last_data_i[POLL_BIT] : 1'b0;
        status_word[TOG_BIT]  = tog_i;
    end

    // Select the bus value: zero when not reading, status when busy
    always_comb begin
        if (!rd_active_i) data_next_o = '0;
        else if (busy_i)  data_next_o = status_word;
        else              data_next_o = array_data_i;
    end

endmodule

// File: rtl/wcs_status_top.sv
// Write completion status reporter top level.
// Assumes: the program engine holds last_addr_i/last_data_i stable while busy;
// the array returns data for addr_i in the same cycle. All outputs are
// registered one cycle after the sampled inputs.
module wcs_status_top
    import wcs_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    input  logic              we_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] array_data_i,
    input  logic [ADDR_W-1:0] last_addr_i,
    input  logic [DATA_W-1:0] last_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_drive_o,
    output logic              rb_pull_o
);

    rd_strobe_t        strobe;
    logic              tog_next;
    logic [DATA_W-1:0] data_next;

    wcs_strobe_decode u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n_i   (ce_n_i),
        .oe_n_i   (oe_n_i),
        .we_n_i   (we_n_i),
        .strobe_o (strobe)
    );

    wcs_toggle_track u_toggle (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy_i     (busy_i),
        .rd_start_i (strobe.start),
        .tog_next_o (tog_next)
    );

    wcs_status_mux #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mux (
        .busy_i       (busy_i),
        .rd_active_i  (strobe.active),
        .tog_i        (tog_next),
        .addr_i       (addr_i),
        .array_data_i (array_data_i),
        .last_addr_i  (last_addr_i),
        .last_data_i  (last_data_i),
        .data_next_o  (data_next)
    );

    // Output registers: bus value, drive enable and ready/busy pull
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_o  <= '0;
            rd_drive_o <= 1'b0;
            rb_pull_o  <= 1'b0;
        end else begin
            rd_data_o  <= data_next;
            rd_drive_o <= strobe.active;
            rb_pull_o  <= busy_i;
        end
    end

endmodule

// File: rtl/wcs_status_checker.sv
// Property checker for wcs_status_top, attached through bind.
// Assumes: DATA_W >= 8 so that bits 5..0 lie below the toggle bit.
module wcs_status_checker #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_i,
    input logic              ce_n_i,
    input logic              oe_n_i,
    input logic              we_n_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [ADDR_W-1:0] last_addr_i,
    input logic [DATA_W-1:0] last_data_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              rd_drive_o,
    input logic              rb_pull_o
);

    localparam int POLL_BIT = DATA_W - 1;
    localparam int TOG_BIT  = DATA_W - 2;

    // Ready/busy pull follows the sampled busy flag
    assert_pull_follows_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rb_pull_o == $past(busy_i)));

    // Drive enable follows the sampled read strobe combination
    assert_drive_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rd_drive_o == $past(!ce_n_i && !oe_n_i && we_n_i)));

    // Quiet bus value when not driving
    assert_quiet_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_drive_o |-> (rd_data_o == '0));

    // Low status bits are zero during a busy read
    assert_low_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_drive_o && rb_pull_o) |-> (rd_data_o[5:0] == 6'd0));

    // Poll bit inverts the last written top bit on a matching busy read
    assert_poll_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && rd_drive_o && rb_pull_o && $past(addr_i == last_addr_i))
        |-> (rd_data_o[POLL_BIT] == !$past(last_data_i[POLL_BIT])));

    // Toggle bit holds within one long busy read
    assert_toggle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && rd_drive_o && rb_pull_o && $past(rd_drive_o) && $past(rb_pull_o))
        |-> $stable(rd_data_o[TOG_BIT]));

endmodule

bind wcs_status_top wcs_status_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_wcs_status_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_i      (busy_i),
    .ce_n_i      (ce_n_i),
    .oe_n_i      (oe_n_i),
    .we_n_i      (we_n_i),
    .addr_i      (addr_i),
    .last_addr_i (last_addr_i),
    .last_data_i (last_data_i),
    .rd_data_o   (rd_data_o),
    .rd_drive_o  (rd_drive_o),
    .rb_pull_o   (rb_pull_o)
);

// File: tb/wcs_status_top_bench.sv
module wcs_status_top_bench;

    localparam int AW = 13;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          busy_i = 1'b0;
    logic          ce_n_i = 1'b1;
    logic          oe_n_i = 1'b1;
    logic          we_n_i = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] array_data_i;
    logic [AW-1:0] last_addr_i = 13'h0AB3;
    logic [DW-1:0] last_data_i = 8'h3C;
    logic [DW-1:0] rd_data_o;
    logic          rd_drive_o;
    logic          rb_pull_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // model state
    bit m_tog = 0, m_pbusy = 0, m_pread = 0;
    bit e_drive = 0, e_pull = 0;
    logic [DW-1:0] e_data = '0;

    always #5 clk = ~clk;

    wcs_status_top u_wcs_status_top (
        .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .ce_n_i(ce_n_i),
        .oe_n_i(oe_n_i), .we_n_i(we_n_i), .addr_i(addr_i),
        .array_data_i(array_data_i), .last_addr_i(last_addr_i),
        .last_data_i(last_data_i), .rd_data_o(rd_data_o),
        .rd_drive_o(rd_drive_o), .rb_pull_o(rb_pull_o)
    );

    function automatic logic [DW-1:0] arr_val(input logic [AW-1:0] a);
        return a[7:0] ^ {a[12:8], 3'b101} ^ 8'hA6;
    endfunction

    assign array_data_i = arr_val(addr_i);

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: drive inputs, update model at the edge, compare after it
    task automatic cycle(input bit b, input bit ce, input bit oe, input bit we, input logic [AW-1:0] a);
        bit r;
        @(negedge clk);
        busy_i = b; ce_n_i = ce; oe_n_i = oe; we_n_i = we; addr_i = a;
        @(posedge clk);
        r = !ce && !oe && we;
        if (rst_n) begin
            if (b && !m_pbusy) m_tog = 0;
            if (b && r && !m_pread) m_tog = !m_tog;
            m_pbusy = b; m_pread = r;
            e_drive = r; e_pull = b;
            if (!r)     e_data = '0;
            else if (b) e_data = {(a == last_addr_i) ? !last_data_i[7] : 1'b0, m_tog, 6'd0};
            else        e_data = arr_val(a);
        end
        @(negedge clk);
        check("R2 drive", {7'd0, rd_drive_o}, {7'd0, e_drive});
        check("R9 pull", {7'd0, rb_pull_o}, {7'd0, e_pull});
        if (!e_drive)    check("R3 quiet", rd_data_o, e_data);
        else if (!e_pull) check("R3 pass", rd_data_o, e_data);
        else begin
            check((a == last_addr_i) ? "R4 poll" : "R5 poll", {7'd0, rd_data_o[7]}, {7'd0, e_data[7]});
            check("R7 toggle", {7'd0, rd_data_o[6]}, {7'd0, e_data[6]});
            check("R6 low", {2'd0, rd_data_o[5:0]}, 8'd0);
        end
    endtask

    initial begin
        logic b6a;
        void'($urandom(32'd4711));
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 data", rd_data_o, 8'd0);
        check("R1 drive", {7'd0, rd_drive_o}, 8'd0);
        check("R1 pull", {7'd0, rb_pull_o}, 8'd0);
        rst_n = 1'b1;

        // R3: idle reads pass array data; write strobe blocks drive (R2)
        cycle(0, 0, 0, 1, 13'h0012);
        cycle(0, 0, 0, 1, 13'h1F00);
        cycle(0, 0, 0, 0, 13'h1F00);
        cycle(0, 1, 1, 1, 13'h0000);

        // R7 collision: read starts on the same edge busy rises -> 1
        cycle(1, 0, 0, 1, last_addr_i);
        cycle(1, 0, 0, 1, last_addr_i);
        b6a = rd_data_o[6];
        cycle(1, 0, 0, 1, last_addr_i);
        check("R8 hold", {7'd0, rd_data_o[6]}, {7'd0, b6a});
        check("R7 first busy read", {7'd0, rd_data_o[6]}, 8'd1);
        cycle(1, 0, 1, 1, last_addr_i);
        cycle(1, 0, 1, 1, last_addr_i);
        cycle(1, 0, 0, 1, 13'h0005);
        check("R7 second busy read", {7'd0, rd_data_o[6]}, 8'd0);
        // R10: busy falls mid-read
        cycle(0, 0, 0, 1, 13'h0005);
        check("R10 true data", rd_data_o, arr_val(13'h0005));
        cycle(0, 1, 1, 1, 13'h0005);

        // reverse collision: busy rises inside an open read -> 0
        cycle(0, 0, 0, 1, last_addr_i);
        cycle(1, 0, 0, 1, last_addr_i);
        check("R7 rise mid-read", {7'd0, rd_data_o[6]}, 8'd0);
        cycle(0, 1, 1, 1, 13'h0000);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            bit b;
            logic [AW-1:0] a;
            b = (($urandom % 64) < 40) ? busy_i : !busy_i;
            a = (($urandom % 3) == 0) ? last_addr_i : AW'($urandom);
            if (!b && (($urandom % 16) == 0)) last_data_i = DW'($urandom);
            cycle(b, ($urandom % 5) == 0, ($urandom % 2) == 0, ($urandom % 6) != 0, a);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule